// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a byte-addressed memory that answers as a slave on an I2C-compatible two-wire bus. A fast system clock samples SCL and SDA. The block detects Start and Stop conditions and compares the first byte of each transaction with a fixed device-type nibble and three device-select pins. A write carries a two-byte location, high byte first, followed by any number of data bytes. A read streams bytes from an internal address counter for as long as the master acknowledges.

Every write is stored within the byte time on the bus. The device therefore never goes busy, and it answers its address again at once after a write. A write-protect input blocks all stores but keeps normal acknowledges. SDA is driven only as an open-drain pull-down enable: when `sda_oe_o` is 1 the line is pulled low.

The array depth is set by `MEM_AW`. A full-size part uses 15. The default of 10 keeps elaboration small. Address bits above `MEM_AW` are ignored.

Top module: `twm_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, and the block stays off the bus until a Start arrives.
- R2: A Start (SDA falling while SCL is high) aborts any transfer, including a byte that is only partly shifted. The block then waits for a device byte. A Stop (SDA rising while SCL is high) aborts the transfer and releases SDA. An aborted byte is neither stored nor counted.
- R3: A device byte is acknowledged only when its bits 7..4 equal 4'b1010 and its bits 3..1 equal `dev_sel_i`. On a mismatch the block drives nothing until the next Start, and later bytes get no acknowledge.
- R4: In a write, byte 2 is address bits 15..8 and byte 3 is address bits 7..0. Bits at or above `MEM_AW` are ignored. Each later byte is stored at the counter.
- R5: In a receive phase, the block pulls SDA low only during the ninth clock of a byte, as its acknowledge.
- R6: In a read, the byte goes out MSB first. A master acknowledge (SDA low on the ninth clock) starts the next byte. A not-acknowledge ends the read, and SDA stays released for the following clocks.
- R7: Data is captured on SCL rising. The output changes only after SCL falls, so SDA is stable while SCL is high.
- R8: The address counter steps after every byte written or read, and it wraps from all ones to 0.
- R9: A read with no address phase before it returns data from the current counter value.
- R10: A random read is a write of the two address bytes, then a repeated Start with bit 0 of the device byte set to 1.
- R11: While `wp_i` is 1, data bytes are acknowledged but leave the array unchanged.
- R12: The device byte of a transaction that starts right after a write's Stop is acknowledged with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as resolved on the wire |
| dev_sel_i | input | 3 | Device-select pins, compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks all stores |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Assertions check these rules on every cycle: the pull-down lets go after each Start and Stop, it moves only while SCL is low, it stays within the acknowledge clock in receive phases, and it is idle whenever the controller is idle. The bench scenarios are the only check of data correctness: stored and returned bytes, counter wrap, the address-select sweep, random and current-address reads, protected writes and aborted partial bytes.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } twm_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int DW = 8;
  localparam logic [3:0] ACK_BIT = 4'd8;
  localparam logic [3:0] END_BIT = 4'd9;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  twm_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [DW-1:0]     rx_q, tx_q, ahi_q;
  logic [MEM_AW-1:0] addr_q;
  logic              rd_mode_q, mack_q, oe_q;
  logic              mem_we, dev_hit;
  logic [DW-1:0]     rdata;

  assign dev_hit = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == dev_sel_i);
  assign mem_we  = scl_fall && !start_det && !stop_det && state_q == ST_WR &&
                   bit_cnt_q == ACK_BIT && !wp_i;

  twm_mem #(.AW(MEM_AW), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(addr_q),
    .wdata_i(rx_q),
    .raddr_i(addr_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ahi_q     <= '0;
      addr_q    <= '0;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q < ACK_BIT) rx_q <= {rx_q[DW-2:0], sda_s};
        if (bit_cnt_q == ACK_BIT) mack_q <= ~sda_s;
        if (bit_cnt_q != END_BIT) bit_cnt_q <= bit_cnt_q + 4'd1;
      end else if (scl_fall) begin
        if (bit_cnt_q == ACK_BIT) begin
          // byte complete: acknowledge, or hand the bus back after a read byte
          unique case (state_q)
            ST_DEV: begin
              if (dev_hit) begin
                oe_q      <= 1'b1;
                rd_mode_q <= rx_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              ahi_q <= rx_q;
              oe_q  <= 1'b1;
            end
            ST_ALO: begin
              addr_q <= MEM_AW'({ahi_q, rx_q});
              oe_q   <= 1'b1;
            end
            ST_WR: begin
              addr_q <= addr_q + 1'b1;
              oe_q   <= 1'b1;
            end
            ST_RD: begin
              addr_q <= addr_q + 1'b1;
              oe_q   <= 1'b0;
            end
            default: ;
          endcase
        end else if (bit_cnt_q == END_BIT) begin
          bit_cnt_q <= '0;
          oe_q      <= 1'b0;
          unique case (state_q)
            ST_DEV: begin
              if (rd_mode_q) begin
                state_q <= ST_RD;
                tx_q    <= rdata;
                oe_q    <= ~rdata[DW-1];
              end else begin
                state_q <= ST_AHI;
              end
            end
            ST_AHI: state_q <= ST_ALO;
            ST_ALO: state_q <= ST_WR;
            ST_RD: begin
              if (mack_q) begin
                tx_q <= rdata;
                oe_q <= ~rdata[DW-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (state_q == ST_RD && bit_cnt_q != 4'd0) begin
          oe_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o) else $error("start did not release SDA"); // R2
  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_oe_o)) else $error("stop did not idle"); // R2
  AST_OE_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && scl_s) |-> $past(start_det || stop_det)) else $error("SDA moved with SCL high"); // R7
  AST_ACK_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && state_q != ST_RD) |-> bit_cnt_q >= ACK_BIT) else $error("drive outside ack clock"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o) else $error("idle but driving"); // R3
  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= END_BIT) else $error("bit counter out of range"); // R5
endmodule

// File: tb/sim_twm_slave.sv
module sim_twm_slave;
  localparam int AW = 10;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic oe;
  logic sda_line;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [1 << AW];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~oe;

  twm_slave #(.MEM_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_sel_i(SEL), .wp_i(wp), .sda_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(4);
    scl = 1'b1; hold(8);
    sda_m = 1'b0; hold(8);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    scl = 1'b0; hold(4);
    sda_m = 1'b0; hold(4);
    scl = 1'b1; hold(8);
    sda_m = 1'b1; hold(8);
  endtask

  task automatic send_bit(input bit b);
    scl = 1'b0; hold(4);
    sda_m = b; hold(4);
    scl = 1'b1; hold(8);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    hold(4); sda_m = 1'b1; hold(4);
    scl = 1'b1; hold(4);
    ack = ~sda_line;
    hold(4); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s1, s2;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; hold(8);
      scl = 1'b1; hold(2);
      s1 = sda_line; hold(4);
      s2 = sda_line; hold(2);
      chk(s1 == s2, "R7 stable while SCL high", s2, s1);
      b[i] = s1;
    end
    scl = 1'b0; hold(4);
    sda_m = ~mack; hold(4);
    scl = 1'b1; hold(8);
    scl = 1'b0; hold(4);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [15:0] a);
    bit ack;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, ack);
    chk(ack, "R3 device ack", ack, 1);
    send_byte(a[15:8], ack);
    chk(ack, "R4 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R4 addr lo ack", ack, 1);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int a;
    hold(5);
    chk(oe == 1'b0, "R1 reset release", oe, 0);
    rst_n = 1'b1;
    hold(10);
    chk(oe == 1'b0 && sda_line == 1'b1, "R1 idle after reset", oe, 0);

    // select sweep over all device-select codes
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (3'(s) == SEL), "R3 select sweep", ack, 3'(s) == SEL);
      bus_stop();
    end
    // wrong type nibble, then a later byte must stay unacknowledged
    bus_start();
    send_byte({4'b1011, SEL, 1'b0}, ack);
    chk(!ack, "R3 type mismatch", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 silent after mismatch", ack, 0);
    bus_stop();

    // sequential write across the wrap, top address bits set
    set_addr(16'h83F0);
    for (int i = 0; i < 40; i++) begin
      send_byte(pat(i), ack);
      chk(ack, "R4 data ack", ack, 1);
      exp_mem[(16'h3F0 + i) & ((1 << AW) - 1)] = pat(i);
    end
    bus_stop();

    // immediate re-address, then random read
    set_addr(16'h7BF0);
    chk(1'b1, "R12 readdress after write", 1, 1);
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, ack);
    chk(ack, "R10 read device ack", ack, 1);
    for (int i = 0; i < 32; i++) begin
      recv_byte(i != 31, d);
      a = (16'h3F0 + i) & ((1 << AW) - 1);
      chk(d == exp_mem[a], "R8 R10 sequential read", d, exp_mem[a]);
    end
    // current-address read continues at 0x010
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, ack);
    chk(ack, "R9 device ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == exp_mem[16'h010], "R9 current read", d, exp_mem[16'h010]);
    // after NAK the line stays released
    for (int i = 0; i < 9; i++) begin
      send_bit(1'b1);
      chk(sda_line == 1'b1, "R6 released after nak", sda_line, 1);
    end
    bus_stop();

    // write protect: acked, not stored
    wp = 1'b1;
    set_addr(16'h03F4);
    for (int i = 0; i < 4; i++) begin
      send_byte(~pat(i), ack);
      chk(ack, "R11 protected ack", ack, 1);
    end
    bus_stop();
    wp = 1'b0;
    set_addr(16'h03F4);
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk(d == exp_mem[16'h3F4 + i], "R11 protected unchanged", d, exp_mem[16'h3F4 + i]);
    end
    bus_stop();

    // partial byte aborted by repeated start
    set_addr(16'h0005);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, ack);
    chk(ack, "R2 ack after abort start", ack, 1);
    recv_byte(1'b0, d);
    chk(d == exp_mem[16'h005], "R2 partial byte dropped", d, exp_mem[16'h005]);
    bus_stop();

    // stop in the middle of a data byte
    set_addr(16'h0006);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop();
    chk(sda_line == 1'b1, "R2 released after stop", sda_line, 1);
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d == exp_mem[16'h006], "R2 stop abort no store", d, exp_mem[16'h006]);
    bus_stop();

    // ack is only a ninth-clock pulse
    set_addr(16'h0100);
    send_bit(1'b1);
    chk(sda_line == 1'b1, "R5 no drive mid byte", sda_line, 1);
    bus_stop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule